// File: doc/BRIEF.md
# Dual-Mode Fetch-Execute Sequencer

This block is the control unit of a small processor. It runs a fixed four-state loop for every instruction. In the first state it drives the program counter onto a synchronous instruction memory. In the second it captures the returned word into an instruction register. In the third it carries out the instruction. In the fourth it checks for a pending interrupt before the next fetch. The arithmetic datapath, the register file and memory protection sit outside the block. Its instruction word carries only a 3-bit operation code, a 3-bit vector-slot index and an 8-bit target address.

A privilege bit separates supervisor code (bit value 0) from user code (bit value 1). Only the system-call instruction and the hardware entries (a fault or an interrupt) can move the processor into supervisor mode. The system-call instruction fetches its destination from an eight-entry vector table and branches there. A privileged operation attempted in user mode does not execute. It raises a one-cycle fault pulse and takes the system-call path through a fixed fault slot. The return instruction restores the single saved program counter and drops to user mode.

The states and transitions are as follows:
- `ST_FETCH` always goes to `ST_DECODE`.
- `ST_DECODE` always goes to `ST_EXEC`.
- `ST_EXEC` goes to `ST_HALT` for a halt executed in supervisor mode, and to `ST_INTCHK` otherwise.
- `ST_INTCHK` always goes to `ST_FETCH`.
- `ST_HALT` stays in `ST_HALT` until reset.

Top module: `dualmode_sequencer`

## Requirements
- R1: While reset is low and on its release, the block is in supervisor mode (`mode_user`=0), `halted`=0 and `priv_fault`=0. The first fetch presents address `START_PC` (default 0x10).
- R2: Each instruction takes exactly four cycles: fetch, decode, execute, interrupt check. `imem_en` is high for only the fetch cycle, with `imem_addr` equal to the program counter. The memory word is captured at the end of the following cycle.
- R3: The instruction word is laid out as bits [13:11] operation, [10:8] slot index, [7:0] target. Codes 000 (step) and 111 (spare) advance the PC by one. Code 010 (privileged I/O) also advances the PC by one when it runs in supervisor mode. Code 001 (jump) loads the target.
- R4: Code 100 (system call) works in either mode. It sets supervisor mode, saves PC+1 and loads the PC from vector slot [10:8]. After reset, every slot holds 0x00.
- R5: Code 011 (set vector) is privileged. In supervisor mode it writes the target field into slot [10:8] and advances the PC by one. The table is never written in user mode.
- R6: Code 101 (return) is privileged. It loads the PC from the saved register and sets user mode.
- R7: In user mode, a privileged code (010, 011, 101, 110) has none of its own effect. `priv_fault` goes high for exactly one cycle, mode becomes supervisor, PC+1 is saved, and the PC loads from slot `FAULT_SLOT` (default 7).
- R8: An `irq_req` pulse latches a pending flag. In the interrupt-check state, if the flag is set and the mode is user, the current (already advanced) PC is saved, the PC loads `IRQ_PC` (default 0x40), the mode becomes supervisor and the flag clears. In supervisor mode the flag stays pending.
- R9: Code 110 (halt) in supervisor mode sets `halted`. Both `halted` and the absence of further fetches persist until reset.
- R10: `mode_user` rises only after an executed return. It falls only after a system call, a fault, or an accepted interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_en | output | 1 | Instruction memory read strobe |
| imem_addr | output | ADDR_W | Instruction memory address (program counter) |
| imem_rdata | input | 3+IDX_W+ADDR_W | Instruction word, valid the cycle after `imem_en` |
| irq_req | input | 1 | Interrupt request pulse |
| halted | output | 1 | High once a halt has executed |
| mode_user | output | 1 | Privilege bit: 0 supervisor, 1 user |
| priv_fault | output | 1 | One-cycle pulse on a privileged opcode in user mode |

## Verification
The bench builds the block with its defaults: an 8-bit address, a 3-bit slot index (eight vector slots), start address 0x10, interrupt address 0x40 and fault slot 7. These values make the whole 256-word program space reachable from a bench-side memory model. They also make both the fault slot and the never-written slot 3 reachable, so a system call through slot 3 proves the reset value of the table. A trace of expected fetch addresses and modes covers every opcode in both modes. A second program places one interrupt while in supervisor mode and one while in user mode.

// File: rtl/seqr_pkg.sv
package seqr_pkg;

    typedef enum logic [2:0] {
        OP_STEP   = 3'b000,
        OP_JUMP   = 3'b001,
        OP_IO     = 3'b010,
        OP_SETVEC = 3'b011,
        OP_SCALL  = 3'b100,
        OP_RET    = 3'b101,
        OP_HALT   = 3'b110,
        OP_SPARE  = 3'b111
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_INTCHK,
        ST_HALT
    } state_e;

    typedef enum logic [2:0] {
        PC_HOLD,
        PC_INC,
        PC_LOAD,
        PC_CALL,
        PC_IRQ,
        PC_RET
    } pc_cmd_e;

    localparam int unsigned OPC_W = 3;

    function automatic logic op_privileged(input opcode_e op);
        return (op == OP_IO) || (op == OP_SETVEC) || (op == OP_RET) || (op == OP_HALT);
    endfunction

endpackage

// File: rtl/seqr_decode.sv
module seqr_decode
    import seqr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned IDX_W  = 3
) (
    input  logic [OPC_W+IDX_W+ADDR_W-1:0] instr,
    input  logic                          mode_user,
    output opcode_e                       op,
    output logic [IDX_W-1:0]              slot,
    output logic [ADDR_W-1:0]             target,
    output logic                          fault
);
    localparam int unsigned INSTR_W = OPC_W + IDX_W + ADDR_W;

    always_comb begin
        op     = opcode_e'(instr[INSTR_W-1 -: OPC_W]);
        slot   = instr[ADDR_W +: IDX_W];
        target = instr[ADDR_W-1:0];
        fault  = op_privileged(op) && mode_user;
    end

endmodule

// File: rtl/seqr_vtable.sv
module seqr_vtable #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_slot,
    input  logic [ADDR_W-1:0] wr_vec,
    input  logic [IDX_W-1:0]  rd_slot,
    output logic [ADDR_W-1:0] rd_vec
);
    localparam int unsigned SLOTS = 1 << IDX_W;

    logic [ADDR_W-1:0] slot_vec [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [ADDR_W-1:0] vec_q;
        logic              hit;

        assign hit = wr_en && (wr_slot == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vec_q <= '0;
            end else if (hit) begin
                vec_q <= wr_vec;
            end
        end

        assign slot_vec[g] = vec_q;
    end

    assign rd_vec = slot_vec[rd_slot];

endmodule

// File: rtl/seqr_pc.sv
module seqr_pc
    import seqr_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] START_PC = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pc_cmd_e           cmd,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] saved
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc    <= START_PC;
            saved <= '0;
        end else begin
            unique case (cmd)
                PC_INC:  pc <= pc + 1'b1;
                PC_LOAD: pc <= load_val;
                PC_CALL: begin
                    saved <= pc + 1'b1;
                    pc    <= load_val;
                end
                PC_IRQ: begin
                    saved <= pc;
                    pc    <= load_val;
                end
                PC_RET:  pc <= saved;
                default: pc <= pc;
            endcase
        end
    end

endmodule

// File: rtl/dualmode_sequencer.sv
module dualmode_sequencer
    import seqr_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 8,
    parameter int unsigned       IDX_W      = 3,
    parameter logic [ADDR_W-1:0] START_PC   = 8'h10,
    parameter logic [ADDR_W-1:0] IRQ_PC     = 8'h40,
    parameter logic [IDX_W-1:0]  FAULT_SLOT = 3'd7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    output logic                          imem_en,
    output logic [ADDR_W-1:0]             imem_addr,
    input  logic [OPC_W+IDX_W+ADDR_W-1:0] imem_rdata,
    input  logic                          irq_req,
    output logic                          halted,
    output logic                          mode_user,
    output logic                          priv_fault
);
    localparam int unsigned INSTR_W = OPC_W + IDX_W + ADDR_W;

    state_e               state_q, state_d;
    logic [INSTR_W-1:0]   ir_q;
    logic                 mode_q;
    logic                 pend_q;
    logic                 fault_q;

    opcode_e              dec_op;
    logic [IDX_W-1:0]     dec_slot;
    logic [ADDR_W-1:0]    dec_target;
    logic                 dec_fault;

    pc_cmd_e              pc_cmd;
    logic [ADDR_W-1:0]    pc_load;
    logic [ADDR_W-1:0]    pc_q;
    logic [ADDR_W-1:0]    saved_pc;

    logic                 tbl_we;
    logic [IDX_W-1:0]     tbl_rd_slot;
    logic [ADDR_W-1:0]    tbl_vec;

    logic                 go_sup;
    logic                 go_user;
    logic                 take_irq;
    logic                 fault_evt;

    seqr_decode #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_decode (
        .instr     (ir_q),
        .mode_user (mode_q),
        .op        (dec_op),
        .slot      (dec_slot),
        .target    (dec_target),
        .fault     (dec_fault)
    );

    assign tbl_rd_slot = dec_fault ? FAULT_SLOT : dec_slot;

    seqr_vtable #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_vtable (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_slot (dec_slot),
        .wr_vec  (dec_target),
        .rd_slot (tbl_rd_slot),
        .rd_vec  (tbl_vec)
    );

    seqr_pc #(
        .ADDR_W   (ADDR_W),
        .START_PC (START_PC)
    ) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (pc_cmd),
        .load_val (pc_load),
        .pc       (pc_q),
        .saved    (saved_pc)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: state_d = ST_EXEC;
            ST_EXEC:   state_d = (dec_op == OP_HALT && !dec_fault) ? ST_HALT : ST_INTCHK;
            ST_INTCHK: state_d = ST_FETCH;
            ST_HALT:   state_d = ST_HALT;
            default:   state_d = ST_FETCH;
        endcase
    end

    // Per-state controls
    always_comb begin
        pc_cmd    = PC_HOLD;
        pc_load   = dec_target;
        tbl_we    = 1'b0;
        go_sup    = 1'b0;
        go_user   = 1'b0;
        take_irq  = 1'b0;
        fault_evt = 1'b0;
        unique case (state_q)
            ST_EXEC: begin
                if (dec_fault) begin
                    pc_cmd    = PC_CALL;
                    pc_load   = tbl_vec;
                    go_sup    = 1'b1;
                    fault_evt = 1'b1;
                end else begin
                    unique case (dec_op)
                        OP_JUMP: begin
                            pc_cmd = PC_LOAD;
                        end
                        OP_SETVEC: begin
                            pc_cmd = PC_INC;
                            tbl_we = 1'b1;
                        end
                        OP_SCALL: begin
                            pc_cmd  = PC_CALL;
                            pc_load = tbl_vec;
                            go_sup  = 1'b1;
                        end
                        OP_RET: begin
                            pc_cmd  = PC_RET;
                            go_user = 1'b1;
                        end
                        OP_HALT: begin
                            pc_cmd = PC_HOLD;
                        end
                        default: begin
                            pc_cmd = PC_INC;
                        end
                    endcase
                end
            end
            ST_INTCHK: begin
                if (pend_q && mode_q) begin
                    pc_cmd   = PC_IRQ;
                    pc_load  = IRQ_PC;
                    go_sup   = 1'b1;
                    take_irq = 1'b1;
                end
            end
            default: begin
                pc_cmd = PC_HOLD;
            end
        endcase
    end

    // Instruction register, mode bit, interrupt pending, fault pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q    <= '0;
            mode_q  <= 1'b0;
            pend_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            if (state_q == ST_DECODE) begin
                ir_q <= imem_rdata;
            end
            if (go_sup) begin
                mode_q <= 1'b0;
            end else if (go_user) begin
                mode_q <= 1'b1;
            end
            pend_q  <= (pend_q && !take_irq) || irq_req;
            fault_q <= fault_evt;
        end
    end

    assign imem_en    = (state_q == ST_FETCH);
    assign imem_addr  = pc_q;
    assign halted     = (state_q == ST_HALT);
    assign mode_user  = mode_q;
    assign priv_fault = fault_q;

endmodule

// File: rtl/seqr_chk.sv
module seqr_chk
    import seqr_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input state_e  state,
    input opcode_e op,
    input logic    fault,
    input logic    tbl_we,
    input logic    imem_en,
    input logic    halted,
    input logic    mode_user,
    input logic    priv_fault
);

    AST_FETCH_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        imem_en |=> !imem_en); // R2

    AST_TABLE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> !mode_user); // R5

    AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        priv_fault |=> !priv_fault); // R7

    AST_FAULT_SUP: assert property (@(posedge clk) disable iff (!rst_n)
        priv_fault |-> !mode_user); // R7

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !imem_en)); // R9

    AST_USER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_user) |-> $past(state == ST_EXEC && op == OP_RET && !fault)); // R10

    AST_SUP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_user) |-> ($past(state == ST_EXEC) || $past(state == ST_INTCHK))); // R10

endmodule

bind dualmode_sequencer seqr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state_q),
    .op         (dec_op),
    .fault      (dec_fault),
    .tbl_we     (tbl_we),
    .imem_en    (imem_en),
    .halted     (halted),
    .mode_user  (mode_user),
    .priv_fault (priv_fault)
);

// File: tb/tb_dualmode_sequencer.sv
module tb_dualmode_sequencer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        imem_en;
    logic [7:0]  imem_addr;
    logic [13:0] imem_rdata = '0;
    logic        irq_req;
    logic        halted;
    logic        mode_user;
    logic        priv_fault;

    logic [13:0] mem [256];

    int errors   = 0;
    int checks   = 0;
    int faults   = 0;
    int cyc      = 0;

    // entry: [15:12] requirement number, [11] expected mode, [7:0] fetch address
    localparam logic [15:0] TRACE_A [21] = '{
        16'h1010,  // R1 first fetch
        16'h5011,  // R5 set vectors in supervisor
        16'h5012,
        16'h3013,  // R3 privileged I/O runs in supervisor
        16'h3014,
        16'h4060,  // R4 system call through slot 2
        16'hA815,  // R10 return enters user mode
        16'h3816,  // R3 step
        16'h3820,  // R3 jump
        16'h4030,  // R4 system call from user via slot 1
        16'h6821,  // R6 return to saved PC
        16'h7050,  // R7 set-vector in user faults to slot 7
        16'h6822,
        16'h7030,  // R7 slot 1 not rewritten
        16'h6823,
        16'h7050,  // R7 halt in user faults
        16'h7824,  // R7 no halt took place
        16'h3825,  // R3 spare code steps
        16'h7050,  // R7 return in user faults
        16'h6826,
        16'h4000   // R4 slot 3 holds its reset value
    };

    localparam logic [15:0] TRACE_B [11] = '{
        16'h8010, 16'h8000, 16'h8040, 16'h8041, 16'h8811, 16'h8812,
        16'h8813, 16'h8040, 16'h8041, 16'h8814, 16'h8815
    };

    dualmode_sequencer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_en    (imem_en),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .irq_req    (irq_req),
        .halted     (halted),
        .mode_user  (mode_user),
        .priv_fault (priv_fault)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (imem_en) imem_rdata <= mem[imem_addr];
    end

    always @(negedge clk) begin
        cyc++;
        if (rst_n && priv_fault) faults++;
        if (cyc == 20000) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog: actual=%0d cycles expected<20000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [13:0] iw(input logic [2:0] op, input logic [2:0] slot,
                                       input logic [7:0] tgt);
        return {op, slot, tgt};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_fetch(output int gap);
        gap = 0;
        forever begin
            @(negedge clk);
            gap++;
            if (imem_en || gap >= 40) break;
        end
    endtask

    task automatic see_fetch(input logic [15:0] e);
        string req;
        req = $sformatf("R%0d", e[15:12]);
        chk(imem_en && imem_addr == e[7:0] && mode_user == e[11], req, "fetch {en,mode,addr}",
            {imem_en, mode_user, imem_addr}, {1'b1, e[11], e[7:0]});
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        irq_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(mode_user == 1'b0, "R1", "mode in reset", mode_user, 0);
        chk(halted == 1'b0, "R1", "halted in reset", halted, 0);
        chk(priv_fault == 1'b0, "R1", "fault in reset", priv_fault, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        int gap;
        int en_seen;

        // program A: every opcode in both modes
        for (int i = 0; i < 256; i++) mem[i] = '0;
        mem[8'h10] = iw(3'b011, 3'd1, 8'h30);
        mem[8'h11] = iw(3'b011, 3'd7, 8'h50);
        mem[8'h12] = iw(3'b011, 3'd2, 8'h60);
        mem[8'h13] = iw(3'b010, 3'd0, 8'h00);
        mem[8'h14] = iw(3'b100, 3'd2, 8'h00);
        mem[8'h60] = iw(3'b101, 3'd0, 8'h00);
        mem[8'h15] = iw(3'b000, 3'd0, 8'h00);
        mem[8'h16] = iw(3'b001, 3'd0, 8'h20);
        mem[8'h20] = iw(3'b100, 3'd1, 8'h00);
        mem[8'h30] = iw(3'b101, 3'd0, 8'h00);
        mem[8'h21] = iw(3'b011, 3'd1, 8'h70);
        mem[8'h50] = iw(3'b101, 3'd0, 8'h00);
        mem[8'h22] = iw(3'b100, 3'd1, 8'h00);
        mem[8'h23] = iw(3'b110, 3'd0, 8'h00);
        mem[8'h24] = iw(3'b111, 3'd0, 8'h00);
        mem[8'h25] = iw(3'b101, 3'd0, 8'h00);
        mem[8'h26] = iw(3'b100, 3'd3, 8'h00);
        mem[8'h00] = iw(3'b110, 3'd0, 8'h00);

        do_reset();
        for (int i = 0; i < 21; i++) begin
            if (i == 0) begin
                gap = 4;
            end else begin
                wait_fetch(gap);
                chk(gap == 4, "R2", "cycles between fetches", gap, 4);
            end
            see_fetch(TRACE_A[i]);
        end

        // R9: halt in supervisor stops everything
        en_seen = 0;
        repeat (24) begin
            @(negedge clk);
            if (imem_en) en_seen++;
        end
        chk(halted == 1'b1, "R9", "halted after supervisor halt", halted, 1);
        chk(en_seen == 0, "R9", "fetches after halt", en_seen, 0);
        chk(faults == 3, "R7", "fault pulse cycles", faults, 3);

        // program B: interrupt held in supervisor, then taken in user mode (R8)
        for (int i = 0; i < 256; i++) mem[i] = '0;
        mem[8'h10] = iw(3'b100, 3'd0, 8'h00);
        mem[8'h00] = iw(3'b101, 3'd0, 8'h00);
        mem[8'h41] = iw(3'b101, 3'd0, 8'h00);

        do_reset();
        for (int i = 0; i < 11; i++) begin
            if (i != 0) wait_fetch(gap);
            see_fetch(TRACE_B[i]);
            if (i == 0 || i == 6) begin
                irq_req = 1'b1;
                @(negedge clk);
                irq_req = 1'b0;
            end
        end
        chk(priv_fault == 1'b0 && halted == 1'b0, "R8", "no fault or halt from interrupts",
            {priv_fault, halted}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule